// File: doc/BRIEF.md
# Carry-Chained Integer ALU

A registered 64-bit integer arithmetic and logic unit for a register machine. Each accepted operation takes a first operand from a register value and a second operand that is either a register value or a short immediate, selected per operation. It performs addition and subtraction, with variants that chain a carry or borrow taken from a status flag input, along with four bitwise operations and three shifts. The unit returns the result together with a fresh carry/borrow flag and a zero flag for the surrounding status register.

The same flag bit serves as carry for additions and as borrow for subtractions, so multi-word arithmetic is built by issuing a plain add (or subtract) on the low word and carry-chained forms on the higher words. Bitwise and shift operations pass the incoming flag through untouched, so a chain may be interleaved with them. Results appear one clock after the operation is accepted and hold until the next accepted operation.

Top module: `carry_alu`

## Requirements
- R1: Operation code 0 yields `{flag_c_out, result} = a + b`, and code 1 yields `a + b + flag_c_in`, where the flag output is the carry out of bit W-1.
- R2: Operation code 2 yields `result = a - b`, and code 3 yields `a - b - flag_c_in` (modulo 2^W); `flag_c_out` is 1 exactly when the unsigned subtraction underflows.
- R3: Codes 4, 5, 6 and 7 yield bitwise AND, OR, NOR (inverse of OR) and XOR of the two operands respectively.
- R4: Code 8 shifts left with zero fill, code 9 shifts right replicating bit W-1, code 10 shifts right with zero fill; the shift amount is the low log2(W) bits of the second operand only.
- R5: With `use_imm` = 1 the second operand is `imm`, sign-extended to W bits for codes 0 to 3 and zero-extended for all other codes; with `use_imm` = 0 it is `src_b` and `imm` has no effect.
- R6: For codes 4 to 15 `flag_c_out` equals `flag_c_in` of the same operation.
- R7: `flag_z_out` is 1 exactly when the W-bit `result` is zero.
- R8: Outputs update on the clock edge that accepts `valid_in` = 1, `valid_out` equals `valid_in` one cycle earlier, and without `valid_in` the result and flags hold their values.
- R9: While `rst_n` is low, `result`, both flags and `valid_out` are 0.
- R10: Codes 11 to 15 are unassigned: they yield a result of 0 (so the zero flag is 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Accept an operation on this edge |
| op | input | 4 | Operation code (see R1 to R4, R10) |
| use_imm | input | 1 | Select immediate as second operand |
| src_a | input | W | First operand |
| src_b | input | W | Register second operand |
| imm | input | IMM_W | Immediate second operand |
| flag_c_in | input | 1 | Carry/borrow flag from status |
| result | output | W | Operation result |
| flag_c_out | output | 1 | New carry/borrow flag |
| flag_z_out | output | 1 | New zero flag |
| valid_out | output | 1 | Result valid this cycle |

## Verification
The bench builds one instance with W = 4 and IMM_W = 3, small enough to sweep every operation code, every operand pair, every immediate and both flag values, which reaches every carry and borrow boundary, every shift amount and both extension paths. A second instance with the default W = 64 and IMM_W = 16 takes directed vectors on the full-width corners: all-ones overflow, borrow through zero, shift amounts at and beyond 63, and a negative immediate against the logical zero-extension.

// File: rtl/carry_alu.sv
module carry_alu #(
  parameter int W     = 64,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_in,
  input  logic [3:0]       op,
  input  logic             use_imm,
  input  logic [W-1:0]     src_a,
  input  logic [W-1:0]     src_b,
  input  logic [IMM_W-1:0] imm,
  input  logic             flag_c_in,
  output logic [W-1:0]     result,
  output logic             flag_c_out,
  output logic             flag_z_out,
  output logic             valid_out
);
  localparam int SH_W = $clog2(W);

  logic [W-1:0] imm_s, imm_z, opnd, res_d;
  logic [W:0]   sum, diff;
  logic         chain, c_d;
  logic [SH_W-1:0] shamt;

  generate
    if (IMM_W < W) begin : g_ext
      assign imm_s = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
      assign imm_z = {{(W-IMM_W){1'b0}}, imm};
    end else begin : g_noext
      assign imm_s = imm[W-1:0];
      assign imm_z = imm[W-1:0];
    end
  endgenerate

  assign opnd  = use_imm ? ((op[3:2] == 2'b00) ? imm_s : imm_z) : src_b;
  assign chain = op[0] & flag_c_in;
  assign sum   = {1'b0, src_a} + {1'b0, opnd} + {{W{1'b0}}, chain};
  assign diff  = {1'b0, src_a} - {1'b0, opnd} - {{W{1'b0}}, chain};
  assign shamt = opnd[SH_W-1:0];

  always_comb begin
    c_d = flag_c_in;
    case (op)
      4'd0, 4'd1: begin res_d = sum[W-1:0];  c_d = sum[W];  end
      4'd2, 4'd3: begin res_d = diff[W-1:0]; c_d = diff[W]; end
      4'd4:  res_d = src_a & opnd;
      4'd5:  res_d = src_a | opnd;
      4'd6:  res_d = ~(src_a | opnd);
      4'd7:  res_d = src_a ^ opnd;
      4'd8:  res_d = src_a << shamt;
      4'd9:  res_d = W'($signed(src_a) >>> shamt);
      4'd10: res_d = src_a >> shamt;
      default: res_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result     <= '0;
      flag_c_out <= 1'b0;
      flag_z_out <= 1'b0;
      valid_out  <= 1'b0;
    end else begin
      valid_out <= valid_in;
      if (valid_in) begin
        result     <= res_d;
        flag_c_out <= c_d;
        flag_z_out <= (res_d == '0);
      end
    end
  end
endmodule

module carry_alu_chk #(
  parameter int W     = 64,
  parameter int IMM_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             valid_in,
  input logic [3:0]       op,
  input logic             use_imm,
  input logic [W-1:0]     src_a,
  input logic [W-1:0]     src_b,
  input logic [IMM_W-1:0] imm,
  input logic             flag_c_in,
  input logic [W-1:0]     result,
  input logic             flag_c_out,
  input logic             flag_z_out,
  input logic             valid_out
);
  assert_valid_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out == $past(valid_in));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> ($stable(result) && $stable(flag_c_out) && $stable(flag_z_out)));

  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> (flag_z_out == (result == '0)));

  assert_carry_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && op[3:2] != 2'b00) |=> (flag_c_out == $past(flag_c_in)));

  assert_add_reg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && op == 4'd0 && !use_imm) |=>
      ({flag_c_out, result} == ({1'b0, $past(src_a)} + {1'b0, $past(src_b)})));

  assert_unassigned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && op > 4'd10) |=> (result == '0));

  assert_reset_R9: assert property (@(posedge clk)
    !rst_n |-> (valid_out == 1'b0 && result == '0 && !flag_c_out && !flag_z_out));
endmodule

bind carry_alu carry_alu_chk #(.W(W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op), .use_imm(use_imm),
  .src_a(src_a), .src_b(src_b), .imm(imm), .flag_c_in(flag_c_in),
  .result(result), .flag_c_out(flag_c_out), .flag_z_out(flag_z_out),
  .valid_out(valid_out)
);

// File: tb/carry_alu_test.sv
module carry_alu_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic       n_v = 0, n_ui = 0, n_c = 0;
  logic [3:0] n_op = 0, n_a = 0, n_b = 0, n_r;
  logic [2:0] n_imm = 0;
  logic       n_co, n_zo, n_vo;

  logic        w_v = 0, w_ui = 0, w_c = 0;
  logic [3:0]  w_op = 0;
  logic [63:0] w_a = 0, w_b = 0, w_r;
  logic [15:0] w_imm = 0;
  logic        w_co, w_zo, w_vo;

  carry_alu #(.W(4), .IMM_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .valid_in(n_v), .op(n_op), .use_imm(n_ui),
    .src_a(n_a), .src_b(n_b), .imm(n_imm), .flag_c_in(n_c),
    .result(n_r), .flag_c_out(n_co), .flag_z_out(n_zo), .valid_out(n_vo));

  carry_alu #(.W(64), .IMM_W(16)) uut_wide (
    .clk(clk), .rst_n(rst_n), .valid_in(w_v), .op(w_op), .use_imm(w_ui),
    .src_a(w_a), .src_b(w_b), .imm(w_imm), .flag_c_in(w_c),
    .result(w_r), .flag_c_out(w_co), .flag_z_out(w_zo), .valid_out(w_vo));

  function automatic logic [64:0] ref_model(int w, int iw, logic [3:0] op,
      logic [63:0] a, logic [63:0] b, logic [15:0] imm, bit ui, bit cin);
    logic [63:0] mask, im, simm, opnd, sa, r;
    logic [64:0] s;
    bit c, ch;
    int amt;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
    im   = {48'd0, imm} & ((64'd1 << iw) - 1);
    simm = im[iw-1] ? (im | ~((64'd1 << iw) - 1)) : im;
    opnd = (ui ? ((op < 4) ? simm : im) : b) & mask;
    a    = a & mask;
    ch   = op[0] & cin;
    c    = cin;
    amt  = int'(opnd & 64'(w - 1));
    sa   = a[w-1] ? (a | ~mask) : a;
    case (op)
      0, 1: begin s = {1'b0, a} + {1'b0, opnd} + 65'(ch); r = s[63:0]; c = (w == 64) ? s[64] : s[w]; end
      2, 3: begin r = a - opnd - 64'(ch); c = ({1'b0, a} < ({1'b0, opnd} + 65'(ch))); end
      4:  r = a & opnd;
      5:  r = a | opnd;
      6:  r = ~(a | opnd);
      7:  r = a ^ opnd;
      8:  r = a << amt;
      9:  r = 64'($signed(sa) >>> amt);
      10: r = a >> amt;
      default: r = 0;
    endcase
    return {c, r & mask};
  endfunction

  function automatic string tag_of(logic [3:0] op);
    if (op < 2) return "R1";
    if (op < 4) return "R2";
    if (op < 8) return "R3";
    if (op < 11) return "R4";
    return "R10";
  endfunction

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag, logic [64:0] e, logic [63:0] r, logic co, logic zo, logic vo, bit logic_op, bit ui);
    string t;
    t = ui ? {tag, "/R5"} : tag;
    check(r == e[63:0], t, "result", r, e[63:0]);
    check(co == e[64], logic_op ? "R6" : t, "carry", 64'(co), 64'(e[64]));
    check(zo == (e[63:0] == 0), "R7", "zero flag", 64'(zo), 64'(e[63:0] == 0));
    check(vo == 1'b1, "R8", "valid_out", 64'(vo), 64'd1);
  endtask

  task automatic run_n(logic [3:0] op, logic [3:0] a, logic [3:0] b, logic [2:0] im, bit ui, bit cin);
    logic [64:0] e;
    n_op = op; n_a = a; n_b = b; n_imm = im; n_ui = ui; n_c = cin; n_v = 1'b1;
    @(posedge clk); @(negedge clk);
    n_v = 1'b0;
    e = ref_model(4, 3, op, 64'(a), 64'(b), 16'(im), ui, cin);
    compare(tag_of(op), e, 64'(n_r), n_co, n_zo, n_vo, op > 3, ui);
  endtask

  task automatic run_w(logic [3:0] op, logic [63:0] a, logic [63:0] b, logic [15:0] im, bit ui, bit cin);
    logic [64:0] e;
    w_op = op; w_a = a; w_b = b; w_imm = im; w_ui = ui; w_c = cin; w_v = 1'b1;
    @(posedge clk); @(negedge clk);
    w_v = 1'b0;
    e = ref_model(64, 16, op, a, b, im, ui, cin);
    compare(tag_of(op), e, w_r, w_co, w_zo, w_vo, op > 3, ui);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(n_r == 0 && !n_co && !n_zo && !n_vo, "R9", "narrow reset", {n_r, n_co, n_zo, n_vo}, 64'd0);
    check(w_r == 0 && !w_co && !w_zo && !w_vo, "R9", "wide reset", w_r | 64'({w_co, w_zo, w_vo}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int op = 0; op < 16; op++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 16; a++) begin
          for (int b = 0; b < 16; b++)
            run_n(4'(op), 4'(a), 4'(b), 3'(b), 1'b0, c[0]);
          for (int i = 0; i < 8; i++)
            run_n(4'(op), 4'(a), 4'(15 - i), 3'(i), 1'b1, c[0]);
        end

    // R8: hold without valid_in, narrow
    run_n(4'd0, 4'd9, 4'd9, 3'd0, 1'b0, 1'b0);
    n_op = 4'd6; n_a = 4'd0; n_b = 4'd0; n_c = 1'b1;
    @(posedge clk); @(negedge clk);
    check(n_r == 4'd2 && n_co && !n_vo, "R8", "hold narrow", {n_r, n_co, n_vo}, {4'd2, 1'b1, 1'b0});

    run_w(4'd0, '1, 64'd1, 16'd0, 1'b0, 1'b0);
    run_w(4'd1, '1, 64'd0, 16'd0, 1'b0, 1'b1);
    run_w(4'd1, 64'h7fff_ffff_ffff_ffff, 64'd0, 16'd0, 1'b0, 1'b1);
    run_w(4'd2, 64'd0, 64'd0, 16'd0, 1'b0, 1'b1);
    run_w(4'd3, 64'd0, 64'd0, 16'd0, 1'b0, 1'b1);
    run_w(4'd3, 64'd5, 64'd4, 16'd0, 1'b0, 1'b1);
    run_w(4'd0, 64'd0, 64'd77, 16'h8000, 1'b1, 1'b0);
    run_w(4'd4, '1, 64'd0, 16'h8000, 1'b1, 1'b1);
    run_w(4'd6, 64'h00ff, 64'hff00, 16'd0, 1'b0, 1'b0);
    run_w(4'd8, 64'd1, 64'd63, 16'd0, 1'b0, 1'b0);
    run_w(4'd8, 64'd1, 64'd64, 16'd0, 1'b0, 1'b1);
    run_w(4'd9, 64'h8000_0000_0000_0000, 64'd63, 16'd0, 1'b0, 1'b0);
    run_w(4'd9, 64'h8000_0000_0000_0000, 64'd0, 16'd127, 1'b1, 1'b0);
    run_w(4'd10, 64'h8000_0000_0000_0000, 64'd63, 16'd0, 1'b0, 1'b1);
    run_w(4'd13, 64'd3, 64'd3, 16'd0, 1'b0, 1'b1);

    // R8: wide hold
    run_w(4'd7, 64'h1234, 64'h0, 16'd0, 1'b0, 1'b0);
    w_op = 4'd0; w_a = '1; w_b = '1;
    @(posedge clk); @(negedge clk);
    check(w_r == 64'h1234 && !w_co && !w_vo, "R8", "hold wide", w_r, 64'h1234);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule